// File: doc/BRIEF.md
# Hub Memory Decoder with Write Protection

This block decodes a 20-bit byte address space shared by all cores and fronts the storage behind it, one 32-bit long per request. Two regions are populated: a main RAM starting at address zero and a 16 KB RAM sitting at the very top of the map. Everything between them is an unpopulated hole that reads as zero and swallows writes. The map never wraps: the top long is the last address, and high addresses never alias onto low ones.

The top region receives the boot image at power-up and holds one debug-interrupt vector long per core. Core 0 owns the highest long, and each following core owns the long just below. A sticky protect control freezes the whole top region against writes while leaving it readable. A loader flag on the request marks writes coming from the image loader. Loader writes are always refused in the reserved vector area at the end of the map, even while the region is unprotected. Every write that is dropped raises a one-cycle rejection pulse.

The main RAM size is a parameter. A production build sets it to 512 KB (0x00000 to 0x7FFFF). The default is smaller, so that the storage array stays modest when the block is elaborated on its own.

Top module: `hub_mem`

## Requirements
- R1: A long written anywhere in main RAM (byte addresses 0 to MAIN_BYTES-1) is returned on rdata_o in the cycle after a later read request to the same long.
- R2: Address bits [1:0] are ignored. Byte-enable bit k alone decides whether write-data bits [8k+7:8k] replace byte lane k of the addressed long.
- R3: A read anywhere between MAIN_BYTES and the base of the top region returns 0x00000000. A write there changes no stored long.
- R4: The top region spans the last TOP_BYTES of the 2^ADDR_W map (0xFC000 to 0xFFFFF by default). It is distinct storage, and writing it never alters main RAM at address zero.
- R5: The vector long of core n sits at 0xFFFFC - 4n. Each of the NUM_CORES slots holds its own value and can be written while the region is unprotected.
- R6: While protect is active, writes into the top region change nothing there, reads of the region return the stored data, and main RAM writes still take effect.
- R7: Protect is inactive after reset. It becomes active on the first cycle with prot_en_i high and stays active until the next reset, whatever prot_en_i does afterwards.
- R8: A write with ldr_i high into the last VEC_RSV longs of the map (0xFFFC0 to 0xFFFFF by default) is refused even when protect is inactive. Loader writes elsewhere in the top region are accepted.
- R9: wr_rej_o is high for exactly the one cycle after a write refused under R3, R6 or R8. It stays low after accepted writes and after reads.
- R10: Out of reset, rdata_o and wr_rej_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| ldr_i | input | 1 | Request comes from the image loader |
| addr_i | input | ADDR_W | Byte address |
| be_i | input | 4 | Byte enables, bit k selects lane k |
| wdata_i | input | 32 | Write data |
| prot_en_i | input | 1 | Sets the sticky top-region protect |
| rdata_o | output | 32 | Read data, one cycle after the read request |
| wr_rej_o | output | 1 | One-cycle pulse after a refused write |

## Verification
The bench uses the default parameters: 16 KB of main RAM, a 16 KB top region and 16 cores, with 16 reserved vector longs. A small main RAM puts the first gap address and the last long below the top region within reach of direct accesses. Sixteen cores fill the entire reserved area with vector slots, so the bench can write and read back every slot on both sides of the loader boundary.

// File: rtl/hub_pkg.sv
package hub_pkg;
  typedef enum logic [1:0] {
    RG_GAP  = 2'd0,
    RG_MAIN = 2'd1,
    RG_TOP  = 2'd2
  } region_e;
endpackage

// File: rtl/hub_decode.sv
module hub_decode
  import hub_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int MAIN_BYTES = 16384,
  parameter int TOP_BYTES  = 16384,
  parameter int VEC_RSV    = 16,
  localparam int MAIN_IW   = $clog2(MAIN_BYTES / 4),
  localparam int TOP_IW    = $clog2(TOP_BYTES / 4)
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output region_e            region_o,
  output logic               in_vec_o,
  output logic [MAIN_IW-1:0] main_idx_o,
  output logic [TOP_IW-1:0]  top_idx_o
);
  localparam logic [ADDR_W:0] MAP_END  = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] MAIN_END = (ADDR_W+1)'(MAIN_BYTES);
  localparam logic [ADDR_W:0] TOP_BASE = MAP_END - (ADDR_W+1)'(TOP_BYTES);
  localparam logic [ADDR_W:0] VEC_BASE = MAP_END - (ADDR_W+1)'(VEC_RSV * 4);

  logic [ADDR_W:0] a_ext;
  assign a_ext = {1'b0, addr_i};

  always_comb begin
    if (a_ext < MAIN_END)       region_o = RG_MAIN;
    else if (a_ext >= TOP_BASE) region_o = RG_TOP;
    else                        region_o = RG_GAP;
  end

  assign in_vec_o   = (a_ext >= VEC_BASE);
  assign main_idx_o = addr_i[MAIN_IW+1:2];
  assign top_idx_o  = addr_i[TOP_IW+1:2];
endmodule

// File: rtl/hub_guard.sv
module hub_guard
  import hub_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    we_i,
  input  logic    ldr_i,
  input  region_e region_i,
  input  logic    in_vec_i,
  input  logic    prot_en_i,
  output logic    wr_main_o,
  output logic    wr_top_o,
  output logic    wr_drop_o
);
  logic prot_q;

  // sticky: only reset clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        prot_q <= 1'b0;
    else if (prot_en_i) prot_q <= 1'b1;
  end

  logic wr;
  assign wr        = req_i && we_i;
  assign wr_main_o = wr && (region_i == RG_MAIN);
  assign wr_top_o  = wr && (region_i == RG_TOP) && !prot_q && !(ldr_i && in_vec_i);
  assign wr_drop_o = wr && !wr_main_o && !wr_top_o;

  AST_PROT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_q |=> prot_q);  // R7
  AST_PROT_ON_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_en_i |=> prot_q);  // R7
endmodule

// File: rtl/hub_bank.sv
module hub_bank #(
  parameter int DEPTH = 4096,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [IW-1:0] idx_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem [DEPTH];

  for (genvar k = 0; k < 4; k++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[k]) mem[idx_i][8*k +: 8] <= wdata_i[8*k +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[idx_i];
  end
endmodule

// File: rtl/hub_mem.sv
module hub_mem
  import hub_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int MAIN_BYTES = 16384,
  parameter int TOP_BYTES  = 16384,
  parameter int NUM_CORES  = 16,
  parameter int VEC_RSV    = 16,
  localparam int MAIN_IW   = $clog2(MAIN_BYTES / 4),
  localparam int TOP_IW    = $clog2(TOP_BYTES / 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ldr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  input  logic              prot_en_i,
  output logic [31:0]       rdata_o,
  output logic              wr_rej_o
);
  initial begin
    if (NUM_CORES > VEC_RSV) $error("vector slots exceed reserved area");
  end

  region_e            region, region_q;
  logic               in_vec, wr_main, wr_top, wr_drop, rd;
  logic [MAIN_IW-1:0] main_idx;
  logic [TOP_IW-1:0]  top_idx;
  logic [31:0]        main_rd, top_rd;

  hub_decode #(.ADDR_W(ADDR_W), .MAIN_BYTES(MAIN_BYTES), .TOP_BYTES(TOP_BYTES),
               .VEC_RSV(VEC_RSV)) u_decode (
    .addr_i(addr_i), .region_o(region), .in_vec_o(in_vec),
    .main_idx_o(main_idx), .top_idx_o(top_idx));

  hub_guard u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .ldr_i(ldr_i),
    .region_i(region), .in_vec_i(in_vec), .prot_en_i(prot_en_i),
    .wr_main_o(wr_main), .wr_top_o(wr_top), .wr_drop_o(wr_drop));

  assign rd = req_i && !we_i;

  hub_bank #(.DEPTH(MAIN_BYTES / 4)) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_main),
    .re_i(rd && region == RG_MAIN), .idx_i(main_idx), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(main_rd));

  hub_bank #(.DEPTH(TOP_BYTES / 4)) u_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_top),
    .re_i(rd && region == RG_TOP), .idx_i(top_idx), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(top_rd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_q <= RG_GAP;
      wr_rej_o <= 1'b0;
    end else begin
      if (rd) region_q <= region;
      wr_rej_o <= wr_drop;
    end
  end

  always_comb begin
    case (region_q)
      RG_MAIN: rdata_o = main_rd;
      RG_TOP:  rdata_o = top_rd;
      default: rdata_o = '0;
    endcase
  end

  AST_GAP_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && region == RG_GAP) |=> (rdata_o == '0));  // R3
  AST_GAP_WR_REJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && region == RG_GAP) |=> wr_rej_o);  // R3
  AST_LDR_VEC_REJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && ldr_i && in_vec) |=> wr_rej_o);  // R8
  AST_MAIN_WR_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && region == RG_MAIN) |=> !wr_rej_o);  // R6
  AST_REJ_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rej_o |-> $past(req_i && we_i));  // R9
  AST_ONE_BANK_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_main, wr_top}));  // R4
endmodule

// File: tb/hub_mem_bench.sv
module hub_mem_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, ldr = 1'b0, prot = 1'b0;
  logic [19:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rej;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  hub_mem u_hub_mem (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .ldr_i(ldr),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .prot_en_i(prot),
    .rdata_o(rdata), .wr_rej_o(rej));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request; outputs sampled one cycle later
  task automatic acc(input logic w, input logic l, input logic [19:0] a,
                     input logic [3:0] b, input logic [31:0] d,
                     output logic [31:0] rd, output logic rj);
    @(negedge clk);
    req = 1'b1; we = w; ldr = l; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; ldr = 1'b0;
    rd = rdata; rj = rej;
  endtask

  task automatic wr(input string tag, input logic l, input logic [19:0] a,
                    input logic [3:0] b, input logic [31:0] d, input logic exp_rej);
    logic [31:0] rd; logic rj;
    acc(1'b1, l, a, b, d, rd, rj);
    chk(tag, {31'b0, rj}, {31'b0, exp_rej});
  endtask

  task automatic rd_chk(input string tag, input logic [19:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic rj;
    acc(1'b0, 1'b0, a, 4'h0, 32'h0, rd, rj);
    chk(tag, rd, exp);
    chk({tag, " no rej on read R9"}, {31'b0, rj}, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; prot = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R10 rdata after reset", rdata, 32'h0);
    chk("R10 rej after reset", {31'b0, rej}, 32'h0);
  endtask

  task automatic t_main();
    wr("R1 wr main 0", 1'b0, 20'h00000, 4'hF, 32'hA5A5_0001, 1'b0);
    wr("R1 wr main last", 1'b0, 20'h03FFC, 4'hF, 32'h1234_5678, 1'b0);
    rd_chk("R1 rd main 0", 20'h00000, 32'hA5A5_0001);
    rd_chk("R1 rd main last", 20'h03FFC, 32'h1234_5678);
    wr("R2 byte lanes", 1'b0, 20'h00106, 4'hF, 32'h1111_1111, 1'b0);
    wr("R2 partial", 1'b0, 20'h00107, 4'b0101, 32'hAABB_CCDD, 1'b0);
    rd_chk("R2 merged lanes", 20'h00104, 32'h11BB_11DD);
  endtask

  task automatic t_gap();
    wr("R3 R9 gap wr rej", 1'b0, 20'h04000, 4'hF, 32'hDEAD_BEEF, 1'b1);
    rd_chk("R3 gap first", 20'h04000, 32'h0);
    wr("R3 gap wr top end", 1'b0, 20'hFBFFC, 4'hF, 32'hDEAD_BEEF, 1'b1);
    rd_chk("R3 gap last", 20'hFBFFC, 32'h0);
    rd_chk("R3 main intact", 20'h03FFC, 32'h1234_5678);
  endtask

  task automatic t_top();
    wr("R4 wr top base", 1'b0, 20'hFC000, 4'hF, 32'hB007_0000, 1'b0);
    rd_chk("R4 rd top base", 20'hFC000, 32'hB007_0000);
    wr("R4 wr top end", 1'b0, 20'hFFFFC, 4'hF, 32'hFFFF_0000, 1'b0);
    rd_chk("R4 no wrap to 0", 20'h00000, 32'hA5A5_0001);
    for (int n = 0; n < 16; n++)
      wr("R5 vec wr", 1'b0, 20'hFFFFC - 20'(4 * n), 4'hF, 32'hC0DE_0000 + 32'(n), 1'b0);
    for (int n = 0; n < 16; n++)
      rd_chk("R5 vec rd", 20'hFFFFC - 20'(4 * n), 32'hC0DE_0000 + 32'(n));
  endtask

  task automatic t_loader();
    wr("R8 ldr vec rej", 1'b1, 20'hFFFC0, 4'hF, 32'h0BAD_0BAD, 1'b1);
    rd_chk("R8 vec unchanged", 20'hFFFC0, 32'hC0DE_000F);
    wr("R8 ldr core0 rej", 1'b1, 20'hFFFFC, 4'hF, 32'h0BAD_0BAD, 1'b1);
    rd_chk("R8 core0 unchanged", 20'hFFFFC, 32'hC0DE_0000);
    wr("R8 ldr below vec ok", 1'b1, 20'hFFFBC, 4'hF, 32'h1D00_0001, 1'b0);
    rd_chk("R8 below vec written", 20'hFFFBC, 32'h1D00_0001);
  endtask

  task automatic t_protect();
    wr("R7 unprot top ok", 1'b0, 20'hFC000, 4'hF, 32'h0000_0001, 1'b0);
    @(negedge clk); prot = 1'b1;
    @(negedge clk); prot = 1'b0;
    wr("R6 prot top rej", 1'b0, 20'hFC000, 4'hF, 32'hEEEE_EEEE, 1'b1);
    rd_chk("R6 prot read ok", 20'hFC000, 32'h0000_0001);
    wr("R6 main under prot", 1'b0, 20'h00200, 4'hF, 32'h5555_AAAA, 1'b0);
    rd_chk("R6 main written", 20'h00200, 32'h5555_AAAA);
    repeat (5) @(negedge clk);
    wr("R7 sticky rej", 1'b0, 20'hFFFFC, 4'hF, 32'hEEEE_EEEE, 1'b1);
    rd_chk("R7 sticky unchanged", 20'hFFFFC, 32'hC0DE_0000);
    do_reset();
    wr("R7 reset clears prot", 1'b0, 20'hFFFFC, 4'hF, 32'h7777_0000, 1'b0);
    rd_chk("R7 write after reset", 20'hFFFFC, 32'h7777_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main();
    t_gap();
    t_top();
    t_loader();
    t_protect();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule